// File: doc/BRIEF.md
# Sample Delay Tuning Controller

This block calibrates the receive-sampling point of a storage-card host interface without software help. Once started, it walks a delay chain through every setting. For each setting it first writes an unlock word to a guarded register and then writes the delay code, given as a thermometer code. It then waits for the interface's internal clock to report stable. Last, it asks the surrounding logic to run one tuning-block transfer and takes back a pass or fail verdict.

The controller tracks two windows of passing settings. The first is the run of passes seen before any failure. The second runs from the first pass after a failure to the last pass of the sweep. The controller picks the longer window and settles on its middle setting. It writes that setting's code out under the same unlock rule, waits for clock-stable once more, and then pulses done. If the clock never settles within the polling budget, it stops and raises an error flag.

The tuning transfer, the verdict on the pattern and the analog delay line all sit outside the block. They are reached through a request/result handshake and a delay-code bus with its write strobe.

Top module: `dly_tune_ctrl`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, err_o, key_we_o, sel_we_o and tune_req_o are 0, and sel_o and best_o are 0.
- R2: Every cycle with sel_we_o=1 comes right after a cycle with key_we_o=1 and key_data_o=0x1234ABCD. A select write with no key write before it would be ignored downstream. The key, select, request and done strobes are never high together.
- R3: A sweep makes exactly 33 select writes. Writes 0 to 31 carry step i's code (2^i)-1, bit k set for every k<i, so step 0 is all zeros. The last write carries the code of the chosen step. sel_o changes only in a cycle with sel_we_o=1.
- R4: After each select write, clk_stable_i is sampled in the first following cycle and then every POLL_CYCLES cycles. The controller moves on at the first sample that sees it high. A high seen at the last sample, POLL_TRIES*POLL_CYCLES cycles after the first, still counts.
- R5: If clk_stable_i is low at all POLL_TRIES+1 samples, err_o rises POLL_TRIES*POLL_CYCLES+2 cycles after the select-write cycle. At the same time busy_o falls. There is no done_o pulse, and no further tuning request that sweep.
- R6: Each step issues exactly one single-cycle tune_req_o, only after clock-stable. The controller then stalls until res_valid_i arrives, with res_pass_i=1 meaning pass. A sweep issues 32 requests.
- R7: Passes before the first fail form window A. Passes after any fail form window B. B starts at its first pass and ends at its last pass, even with fails in between.
- R8: Window A is chosen when its end minus start is at least that of B; otherwise B is chosen. best_o is the chosen start plus half of end minus start, rounded down.
- R9: A negative result is clamped to step 0. This happens when nothing passes, or when the only pass comes after a fail and forms a zero-length B that loses the tie to empty A.
- R10: After the final clock-stable, done_o pulses for exactly one cycle. busy_o is low in the next cycle, and best_o holds the chosen step.
- R11: start_i is ignored while busy_o=1. A start accepted when idle clears err_o and raises busy_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sweep when idle |
| clk_stable_i | input | 1 | Internal clock stable flag |
| res_valid_i | input | 1 | Tuning result strobe |
| res_pass_i | input | 1 | Tuning result, 1 = pass |
| key_we_o | output | 1 | Write strobe for the unlock register |
| key_data_o | output | 32 | Unlock word, 0x1234ABCD when key_we_o is high |
| sel_we_o | output | 1 | Write strobe for the delay select |
| sel_o | output | SEL_W (32) | Thermometer delay code |
| tune_req_o | output | 1 | One-cycle tuning transfer request |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Clock-stable timeout, held until next start |
| best_o | output | IDX_W (5) | Chosen step index |

## Verification
The properties assume the environment is well behaved. res_valid_i is a one-cycle strobe that answers an earlier tune_req_o, with at most one answer per request. start_i and clk_stable_i may change at any time. The bench respects this with a responder that arms on each request and answers once, after 0 to 2 extra cycles that vary with the step. Across the tests, clock-stable is held high, held low, or withheld until the last poll sample.

// File: rtl/dtune_pkg.sv
package dtune_pkg;

    // Sequencer states of the tuning sweep
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY,
        ST_SEL,
        ST_WAIT,
        ST_REQ,
        ST_RESP,
        ST_DONE
    } seq_state_e;

    localparam logic [31:0] UNLOCK_WORD = 32'h1234_ABCD;

endpackage

// File: rtl/dtune_poll.sv
module dtune_poll #(
    parameter int POLL_CYCLES = 250000,
    parameter int POLL_TRIES  = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic stable_i,
    output logic ok_o,
    output logic expire_o
);
    localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int TW = $clog2(POLL_TRIES + 1);

    logic [CW-1:0] gap_q;
    logic [TW-1:0] tries_q;
    logic          sample;

    assign sample   = run_i && (gap_q == '0);
    assign ok_o     = sample && stable_i;
    assign expire_o = sample && !stable_i && (tries_q == TW'(POLL_TRIES));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            gap_q   <= '0;
            tries_q <= '0;
        end else if (sample) begin
            gap_q   <= CW'(POLL_CYCLES - 1);
            tries_q <= tries_q + 1'b1;
        end else begin
            gap_q   <= gap_q - 1'b1;
        end
    end
endmodule

// File: rtl/dtune_window.sv
module dtune_window #(
    parameter int N_STEPS = 32,
    parameter int IDX_W   = $clog2(N_STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             upd_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             pass_i,
    output logic [IDX_W-1:0] best_o
);
    localparam int SW = IDX_W + 1;
    localparam int DW = IDX_W + 2;

    typedef struct packed {
        logic signed [SW-1:0] lo;
        logic signed [SW-1:0] hi;
    } span_t;

    localparam logic signed [SW-1:0] NONE = '1;

    span_t run_a_q, run_b_q;
    logic  fail_seen_q;
    logic signed [SW-1:0] idx_s;

    assign idx_s = $signed({1'b0, idx_i});

    function automatic logic signed [DW-1:0] widen(input logic signed [SW-1:0] v);
        return $signed({v[SW-1], v});
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            run_a_q     <= '{lo: NONE, hi: NONE};
            run_b_q     <= '{lo: NONE, hi: NONE};
            fail_seen_q <= 1'b0;
        end else if (upd_i) begin
            if (!pass_i) begin
                fail_seen_q <= 1'b1;
            end else if (!fail_seen_q) begin
                if (run_a_q.lo == NONE) run_a_q.lo <= idx_s;
                run_a_q.hi <= idx_s;
            end else begin
                if (run_b_q.lo == NONE) run_b_q.lo <= idx_s;
                run_b_q.hi <= idx_s;
            end
        end
    end

    logic signed [DW-1:0] len_a, len_b, base, span, centre;

    always_comb begin
        len_a = widen(run_a_q.hi) - widen(run_a_q.lo);
        len_b = widen(run_b_q.hi) - widen(run_b_q.lo);
        if (len_a >= len_b) begin
            base = widen(run_a_q.lo);
            span = len_a;
        end else begin
            base = widen(run_b_q.lo);
            span = len_b;
        end
        centre = base + (span >>> 1);
        if (centre < 0) best_o = '0;
        else            best_o = centre[IDX_W-1:0];
    end
endmodule

// File: rtl/dtune_seq.sv
module dtune_seq
    import dtune_pkg::*;
#(
    parameter int N_STEPS = 32,
    parameter int SEL_W   = N_STEPS,
    parameter int IDX_W   = $clog2(N_STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stable_ok_i,
    input  logic             stable_expire_i,
    input  logic             res_valid_i,
    input  logic [IDX_W-1:0] best_i,
    output logic             poll_run_o,
    output logic             win_clear_o,
    output logic             win_upd_o,
    output logic [IDX_W-1:0] step_o,
    output logic             key_we_o,
    output logic             sel_we_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             tune_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(N_STEPS - 1);

    seq_state_e       st_q;
    logic [IDX_W-1:0] step_q;
    logic             final_q;
    logic             err_q;
    logic [SEL_W-1:0] sel_q;

    function automatic logic [SEL_W-1:0] therm(input logic [IDX_W-1:0] n);
        logic [SEL_W-1:0] t;
        for (int b = 0; b < SEL_W; b++) t[b] = (b < int'(n));
        return t;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            step_q  <= '0;
            final_q <= 1'b0;
            err_q   <= 1'b0;
            sel_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q    <= ST_KEY;
                    step_q  <= '0;
                    final_q <= 1'b0;
                    err_q   <= 1'b0;
                end
                ST_KEY: begin
                    sel_q <= therm(final_q ? best_i : step_q);
                    st_q  <= ST_SEL;
                end
                ST_SEL: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (stable_expire_i) begin
                        err_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end else if (stable_ok_i) begin
                        st_q <= final_q ? ST_DONE : ST_REQ;
                    end
                end
                ST_REQ: st_q <= ST_RESP;
                ST_RESP: if (res_valid_i) begin
                    if (step_q == LAST_STEP) final_q <= 1'b1;
                    else                     step_q  <= step_q + 1'b1;
                    st_q <= ST_KEY;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign poll_run_o  = (st_q == ST_WAIT);
    assign win_clear_o = (st_q == ST_IDLE) && start_i;
    assign win_upd_o   = (st_q == ST_RESP) && res_valid_i;
    assign step_o      = step_q;
    assign key_we_o    = (st_q == ST_KEY);
    assign sel_we_o    = (st_q == ST_SEL);
    assign sel_o       = sel_q;
    assign tune_req_o  = (st_q == ST_REQ);
    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = (st_q == ST_DONE);
    assign err_o       = err_q;
endmodule

// File: rtl/dly_tune_ctrl.sv
module dly_tune_ctrl
    import dtune_pkg::*;
#(
    parameter int          N_STEPS     = 32,
    parameter int          SEL_W       = N_STEPS,
    parameter int          IDX_W       = $clog2(N_STEPS),
    parameter int          POLL_CYCLES = 250000,
    parameter int          POLL_TRIES  = 20,
    parameter logic [31:0] UNLOCK_KEY  = UNLOCK_WORD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             clk_stable_i,
    input  logic             res_valid_i,
    input  logic             res_pass_i,
    output logic             key_we_o,
    output logic [31:0]      key_data_o,
    output logic             sel_we_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             tune_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [IDX_W-1:0] best_o
);
    logic             poll_run, poll_ok, poll_expire;
    logic             win_clear, win_upd;
    logic [IDX_W-1:0] step_idx;
    logic [IDX_W-1:0] best_idx;

    dtune_poll #(
        .POLL_CYCLES(POLL_CYCLES),
        .POLL_TRIES (POLL_TRIES)
    ) u_poll (
        .clk     (clk),
        .rst     (rst),
        .run_i   (poll_run),
        .stable_i(clk_stable_i),
        .ok_o    (poll_ok),
        .expire_o(poll_expire)
    );

    dtune_window #(
        .N_STEPS(N_STEPS),
        .IDX_W  (IDX_W)
    ) u_window (
        .clk    (clk),
        .rst    (rst),
        .clear_i(win_clear),
        .upd_i  (win_upd),
        .idx_i  (step_idx),
        .pass_i (res_pass_i),
        .best_o (best_idx)
    );

    dtune_seq #(
        .N_STEPS(N_STEPS),
        .SEL_W  (SEL_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .stable_ok_i    (poll_ok),
        .stable_expire_i(poll_expire),
        .res_valid_i    (res_valid_i),
        .best_i         (best_idx),
        .poll_run_o     (poll_run),
        .win_clear_o    (win_clear),
        .win_upd_o      (win_upd),
        .step_o         (step_idx),
        .key_we_o       (key_we_o),
        .sel_we_o       (sel_we_o),
        .sel_o          (sel_o),
        .tune_req_o     (tune_req_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o)
    );

    assign key_data_o = key_we_o ? UNLOCK_KEY : 32'h0;
    assign best_o     = best_idx;
endmodule

// File: rtl/dly_tune_ctrl_chk.sv
module dly_tune_ctrl_chk #(
    parameter int          SEL_W      = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'h1234_ABCD
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             key_we_o,
    input logic [31:0]      key_data_o,
    input logic             sel_we_o,
    input logic [SEL_W-1:0] sel_o,
    input logic             tune_req_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o
);
    // R2: a select write always follows the unlock write
    p_key_before_sel_r2: assert property (@(posedge clk) disable iff (rst)
        sel_we_o |-> ($past(key_we_o) && $past(key_data_o) == UNLOCK_KEY));

    // R2: strobes are mutually exclusive
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({key_we_o, sel_we_o, tune_req_o, done_o}));

    // R3: written codes are thermometer codes
    p_therm_code_r3: assert property (@(posedge clk) disable iff (rst)
        sel_we_o |-> (((sel_o + SEL_W'(1)) & sel_o) == '0));

    // R3: the select bus moves only with its strobe
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_o) |-> sel_we_o);

    // R6: tuning request lasts one cycle
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        tune_req_o |=> !tune_req_o);

    // R10: done is a single pulse and the block goes idle after it
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    // R5: an error ends the sweep without done
    p_err_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (!busy_o && !done_o));

    // R11: a sweep begins only on a start request
    p_busy_from_start_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind dly_tune_ctrl dly_tune_ctrl_chk #(
    .SEL_W     (SEL_W),
    .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (.*);

// File: tb/test_dly_tune_ctrl.sv
module test_dly_tune_ctrl;
    localparam int          P   = 4;
    localparam int          T   = 20;
    localparam logic [31:0] KEY = 32'h1234_ABCD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        clk_stable_i = 1'b1;
    logic        res_valid_i = 1'b0;
    logic        res_pass_i = 1'b0;
    logic        key_we_o, sel_we_o, tune_req_o, busy_o, done_o, err_o;
    logic [31:0] key_data_o, sel_o;
    logic [4:0]  best_o;

    always #2 clk = ~clk;

    dly_tune_ctrl #(.POLL_CYCLES(P), .POLL_TRIES(T)) i_dly_tune_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .clk_stable_i(clk_stable_i),
        .res_valid_i(res_valid_i), .res_pass_i(res_pass_i),
        .key_we_o(key_we_o), .key_data_o(key_data_o), .sel_we_o(sel_we_o),
        .sel_o(sel_o), .tune_req_o(tune_req_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .best_o(best_o)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // environment model state
    int exp_step, nsel, nreq, key_viol, order_err, req_viol;
    int stab_mode = 0, stab_cnt = 0, cur_step = 0, lat = 0;
    bit key_prev = 0, pend = 0;
    logic [31:0] final_sel = '0, pattern = '0;

    function automatic logic [31:0] therm(input int k);
        return 32'((64'd1 << k) - 64'd1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // guarded select register, clock-stable source and tuning responder
    always @(negedge clk) begin
        if (!rst) begin
            res_valid_i = 1'b0;
            if (sel_we_o) begin
                nsel++;
                if (!key_prev) key_viol++;
                else begin
                    if (exp_step < 32) begin
                        if (sel_o != therm(exp_step)) order_err++;
                        exp_step++;
                    end else final_sel = sel_o;
                    cur_step = $countones(sel_o);
                end
                if (stab_mode == 2) begin clk_stable_i = 1'b0; stab_cnt = 0; end
            end else if (stab_mode == 2 && !clk_stable_i) begin
                stab_cnt++;
                if (stab_cnt == T * P + 1) clk_stable_i = 1'b1;
            end
            key_prev = key_we_o && (key_data_o == KEY);
            if (pend) begin
                if (lat == 0) begin
                    res_valid_i = 1'b1;
                    res_pass_i  = pattern[cur_step];
                    pend = 0;
                end else lat--;
            end
            if (tune_req_o) begin
                if (pend) req_viol++;
                if (clk_stable_i == 1'b0 && stab_mode == 1) req_viol++;
                nreq++;
                pend = 1;
                lat  = cur_step % 3;
            end
        end
    end

    task automatic clear_model(input logic [31:0] pat);
        pattern = pat; exp_step = 0; nsel = 0; nreq = 0;
        key_viol = 0; order_err = 0; req_viol = 0; final_sel = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R1", "status in reset", {busy_o, done_o, err_o}, 0);
        check(!key_we_o && !sel_we_o && !tune_req_o, "R1", "strobes in reset",
              {key_we_o, sel_we_o, tune_req_o}, 0);
        check(sel_o == '0 && best_o == '0, "R1", "select/best in reset", sel_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !err_o && sel_o == '0, "R1", "idle after reset", busy_o, 0);
    endtask

    task automatic run_sweep(input logic [31:0] pat, input int best, input string tag,
                             input int poke);
        bit got_done = 0;
        clear_model(pat);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(busy_o && !err_o, "R11", "start accepted", {busy_o, err_o}, 2);
        for (int n = 0; n < 20000 && !got_done && !err_o; n++) begin
            @(negedge clk);
            start_i = (n == poke) ? 1'b1 : 1'b0;
            if (done_o) got_done = 1;
        end
        start_i = 1'b0;
        check(got_done, "R10", "done reached", got_done, 1);
        @(negedge clk);
        check(!done_o && !busy_o, "R10", "done one cycle then idle", {done_o, busy_o}, 0);
        check(best_o == 5'(best), tag, "best step", best_o, best);
        check(final_sel == therm(best), "R3", "final select code", final_sel, therm(best));
        check(nsel == 33 && order_err == 0, "R3", "select write count/order", nsel * 100 + order_err, 3300);
        check(key_viol == 0, "R2", "select writes without key", key_viol, 0);
        check(nreq == 32 && req_viol == 0, "R6", "request count/violations", nreq * 100 + req_viol, 3200);
        check(!err_o, "R4", "no error on sweep", err_o, 0);
    endtask

    task automatic t_timeout();
        int n = 0;
        bit seen = 0;
        clear_model(32'hFFFF_FFFF);
        stab_mode = 1; clk_stable_i = 1'b0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int k = 0; k < 20 && !sel_we_o; k++) @(negedge clk);
        for (int k = 0; k < 500 && !seen; k++) begin
            @(negedge clk);
            n++;
            if (err_o) seen = 1;
            if (done_o) check(0, "R5", "done during timeout", 1, 0);
        end
        check(seen && n == T * P + 2, "R5", "error latency", n, T * P + 2);
        check(!busy_o, "R5", "idle after timeout", busy_o, 0);
        check(nreq == 0, "R5", "no request after timeout", nreq, 0);
        repeat (3) @(negedge clk);
        check(err_o, "R5", "error held", err_o, 1);
        stab_mode = 0; clk_stable_i = 1'b1;
    endtask

    initial begin
        t_reset();
        run_sweep(32'hFFFF_FFFF, 15, "R8", -1);
        run_sweep(32'h007F_FC0F, 16, "R8", -1);
        run_sweep(32'h3FF0_03FF, 4,  "R8", -1);
        run_sweep(32'h0E0F_FFFF, 9,  "R7", -1);
        run_sweep(32'h0000_1008, 7,  "R7", -1);
        run_sweep(32'h0000_0000, 0,  "R9", -1);
        run_sweep(32'h0000_0200, 0,  "R9", -1);
        t_timeout();
        run_sweep(32'hFFFF_FFFF, 15, "R11", 60);
        stab_mode = 2;
        run_sweep(32'h0000_FFF0, 9,  "R4", -1);
        stab_mode = 0; clk_stable_i = 1'b1;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule